// File: doc/BRIEF.md
# Hibernate Power-Mode Sequencer

This block runs in the always-on domain of a dual-core chip. It decides when the chip may drop into its deepest low-power state and brings it back out. Three conditions must all hold for entry: the low-power mode field must pick hibernate, the primary core must signal an idle instruction, and the secondary core must report idle or standby. The block then removes power from both cores, the digital peripherals and the non-retained memory banks. The retention banks stay powered. I/O isolation is raised only when its configuration bit is set.

Wakeup happens in two phases on an active-low wake pin. A falling edge powers up only the clock sources. The pin must then stay low for a programmable minimum number of cycles. A rising edge after that powers up the rest of the chip. If the pin rises too early, the wake is dropped and the clocks are switched off again. On a valid wake the block sets a sticky hibernate reset-cause flag and waits for trim loading. It runs an optional restore phase, clears isolation if firmware has not already done so, and finally releases the secondary core from reset. While the cause flag is set, the boot mode offered to boot logic comes from a dedicated hibernate boot-mode value.

Top module: `hib_seq`

## Requirements
- R1: In RUN (seqState 0), the block moves to ENTER (seqState 1) on the next clock only when lpmMode equals 2'b10, idleExec is 1 and cpu2LowPower is 1 in the same cycle. Otherwise it stays in RUN. One cycle later it reaches HIB (seqState 2).
- R2: In HIB, corePwr, periphPwr, bankPwr and cpu2RstN are 0, and retainPwr is 1. Out of reset, all power outputs and cpu2RstN are 1, oscEn is 1, ioIso is 0 and hibCause is 0.
- R3: On the transition from ENTER to HIB, ioIso takes the value of isoCfg.
- R4: A falling edge on wakeN in HIB moves the block to CLK_UP (seqState 3) one clock later and sets oscEn to 1. corePwr, periphPwr and bankPwr stay 0.
- R5: If wakeN is high in CLK_UP before the low-time counter has reached minLow, the block returns to HIB on the next clock with oscEn 0.
- R6: Once the counter reaches minLow, the block moves to CLK_READY (seqState 4). A high wakeN there leads to POWER_UP (seqState 5) and then to TRIM (seqState 6). On that last step, core, peripheral and bank power turn on and hibCause is set, while cpu2RstN stays 0.
- R7: TRIM holds until trimDone is 1. It then goes to RESTORE (seqState 7) if restoreEn is 1, and otherwise to RELEASE (seqState 8).
- R8: swIsoClr at 1 in RESTORE clears ioIso on the next clock. In any other state it has no effect.
- R9: Leaving RELEASE for RUN, ioIso becomes 0 and cpu2RstN becomes 1.
- R10: hibCause stays set until swCauseClr is 1 or rstN is asserted low.
- R11: bootMode equals bootModeHib while hibCause is 1, and bootModeNorm otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| lpmMode | input | 2 | Low-power mode field, 2'b10 selects hibernate |
| idleExec | input | 1 | Primary core executed an idle instruction |
| cpu2LowPower | input | 1 | Secondary core is in idle or standby |
| isoCfg | input | 1 | Raise I/O isolation during hibernate |
| restoreEn | input | 1 | Run the restore phase after trim |
| wakeN | input | 1 | Active-low wake pin |
| minLow | input | 8 | Minimum wake-low count before clocks count as ready |
| trimDone | input | 1 | Trim loading finished |
| restoreDone | input | 1 | Restore phase finished |
| swIsoClr | input | 1 | Firmware write-one to clear isolation |
| swCauseClr | input | 1 | Firmware write-one to clear the cause flag |
| bootModeHib | input | 4 | Boot mode used after a hibernate wake |
| bootModeNorm | input | 4 | Boot mode used otherwise |
| seqState | output | 4 | Current sequencer state code |
| ioIso | output | 1 | I/O isolation active |
| oscEn | output | 1 | Clock-source power enable |
| corePwr | output | 1 | Core power enable |
| periphPwr | output | 1 | Digital peripheral power enable |
| bankPwr | output | 1 | Non-retained memory bank power enable |
| retainPwr | output | 1 | Retention memory power enable |
| cpu2RstN | output | 1 | Active-low reset to the secondary core |
| hibCause | output | 1 | Sticky hibernate-wake reset cause |
| bootMode | output | 4 | Boot mode presented to boot logic |

## Verification
The assertions check several things on every cycle. Entry follows whenever all three entry conditions meet in RUN. The power domains stay off throughout HIB, and isolation follows isoCfg on entry. The oscillators switch on only when leaving HIB. An early rise always turns the clocks off again. The cause flag rises only out of POWER_UP, and the secondary core comes out of reset only with isolation already clear. Some behaviour shows only in the bench's scenarios: counting the minimum low time and aborting the wake, TRIM waiting for trimDone, the choice between restore and direct release, writes to swIsoClr being ignored outside RESTORE, the cause flag persisting across a second hibernate, and the boot-mode switch.

// File: rtl/hib_pkg.sv
package hib_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN       = 4'd0,
    ST_ENTER     = 4'd1,
    ST_HIB       = 4'd2,
    ST_CLK_UP    = 4'd3,
    ST_CLK_READY = 4'd4,
    ST_POWER_UP  = 4'd5,
    ST_TRIM      = 4'd6,
    ST_RESTORE   = 4'd7,
    ST_RELEASE   = 4'd8
  } hibState_e;

  typedef struct packed {
    logic pwrOff;
    logic oscOn;
    logic oscOff;
    logic pwrOn;
    logic setCause;
    logic isoSwClr;
    logic isoAutoClr;
    logic cpu2Release;
    logic cntEn;
  } hibStrobe_t;
endpackage

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int LPM_W = 2,
  parameter logic [LPM_W-1:0] LPM_HIB = 2'b10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPM_W-1:0] lpmMode,
  input  logic             idleExec,
  input  logic             cpu2LowPower,
  input  logic             wakeN,
  input  logic             wakeFall,
  input  logic             clkOk,
  input  logic             trimDone,
  input  logic             restoreEn,
  input  logic             restoreDone,
  input  logic             swIsoClr,
  output hibState_e        state,
  output hibStrobe_t       strb
);
  hibState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_RUN:
        if (lpmMode == LPM_HIB && idleExec && cpu2LowPower) nextState = ST_ENTER;
      ST_ENTER: begin
        strb.pwrOff = 1'b1;
        nextState   = ST_HIB;
      end
      ST_HIB:
        if (wakeFall) begin
          strb.oscOn = 1'b1;
          nextState  = ST_CLK_UP;
        end
      ST_CLK_UP: begin
        strb.cntEn = 1'b1;
        if (clkOk) nextState = ST_CLK_READY;
        else if (wakeN) begin
          strb.oscOff = 1'b1;
          nextState   = ST_HIB;
        end
      end
      ST_CLK_READY:
        if (wakeN) nextState = ST_POWER_UP;
      ST_POWER_UP: begin
        strb.pwrOn    = 1'b1;
        strb.setCause = 1'b1;
        nextState     = ST_TRIM;
      end
      ST_TRIM:
        if (trimDone) nextState = restoreEn ? ST_RESTORE : ST_RELEASE;
      ST_RESTORE: begin
        strb.isoSwClr = swIsoClr;
        if (restoreDone) nextState = ST_RELEASE;
      end
      ST_RELEASE: begin
        strb.isoAutoClr  = 1'b1;
        strb.cpu2Release = 1'b1;
        nextState        = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end
endmodule

// File: rtl/hib_dp.sv
module hib_dp
  import hib_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BM_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  hibStrobe_t       strb,
  input  logic             isoCfg,
  input  logic             wakeN,
  input  logic [CNT_W-1:0] minLow,
  input  logic             swCauseClr,
  input  logic [BM_W-1:0]  bootModeHib,
  input  logic [BM_W-1:0]  bootModeNorm,
  output logic             wakeFall,
  output logic             clkOk,
  output logic             ioIso,
  output logic             oscEn,
  output logic             domPwr,
  output logic             cpu2RstN,
  output logic             hibCause,
  output logic [BM_W-1:0]  bootMode
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             wakeNq;
  logic [CNT_W-1:0] lowCnt;

  assign wakeFall = wakeNq & ~wakeN;
  assign clkOk    = lowCnt >= minLow;
  assign bootMode = hibCause ? bootModeHib : bootModeNorm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeNq <= 1'b1;
      lowCnt <= '0;
    end else begin
      wakeNq <= wakeN;
      if (!strb.cntEn)            lowCnt <= '0;
      else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioIso    <= 1'b0;
      oscEn    <= 1'b1;
      domPwr   <= 1'b1;
      cpu2RstN <= 1'b1;
    end else begin
      if (strb.pwrOff) begin
        ioIso    <= isoCfg;
        oscEn    <= 1'b0;
        domPwr   <= 1'b0;
        cpu2RstN <= 1'b0;
      end
      if (strb.oscOn)  oscEn  <= 1'b1;
      if (strb.oscOff) oscEn  <= 1'b0;
      if (strb.pwrOn)  domPwr <= 1'b1;
      if (strb.isoSwClr || strb.isoAutoClr) ioIso <= 1'b0;
      if (strb.cpu2Release) cpu2RstN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hibCause <= 1'b0;
    else if (strb.setCause) hibCause <= 1'b1;
    else if (swCauseClr)    hibCause <= 1'b0;
  end
endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_pkg::*;
#(
  parameter int LPM_W = 2,
  parameter logic [LPM_W-1:0] LPM_HIB = 2'b10,
  parameter int CNT_W = 8,
  parameter int BM_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPM_W-1:0] lpmMode,
  input  logic             idleExec,
  input  logic             cpu2LowPower,
  input  logic             isoCfg,
  input  logic             restoreEn,
  input  logic             wakeN,
  input  logic [CNT_W-1:0] minLow,
  input  logic             trimDone,
  input  logic             restoreDone,
  input  logic             swIsoClr,
  input  logic             swCauseClr,
  input  logic [BM_W-1:0]  bootModeHib,
  input  logic [BM_W-1:0]  bootModeNorm,
  output logic [STATE_W-1:0] seqState,
  output logic             ioIso,
  output logic             oscEn,
  output logic             corePwr,
  output logic             periphPwr,
  output logic             bankPwr,
  output logic             retainPwr,
  output logic             cpu2RstN,
  output logic             hibCause,
  output logic [BM_W-1:0]  bootMode
);
  hibState_e  state;
  hibStrobe_t strb;
  logic       wakeFall, clkOk, domPwr;

  hib_ctrl #(.LPM_W(LPM_W), .LPM_HIB(LPM_HIB)) u_ctrl (
    .clk(clk), .rstN(rstN), .lpmMode(lpmMode), .idleExec(idleExec),
    .cpu2LowPower(cpu2LowPower), .wakeN(wakeN), .wakeFall(wakeFall),
    .clkOk(clkOk), .trimDone(trimDone), .restoreEn(restoreEn),
    .restoreDone(restoreDone), .swIsoClr(swIsoClr),
    .state(state), .strb(strb)
  );

  hib_dp #(.CNT_W(CNT_W), .BM_W(BM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .isoCfg(isoCfg), .wakeN(wakeN),
    .minLow(minLow), .swCauseClr(swCauseClr), .bootModeHib(bootModeHib),
    .bootModeNorm(bootModeNorm), .wakeFall(wakeFall), .clkOk(clkOk),
    .ioIso(ioIso), .oscEn(oscEn), .domPwr(domPwr), .cpu2RstN(cpu2RstN),
    .hibCause(hibCause), .bootMode(bootMode)
  );

  assign seqState  = state;
  assign corePwr   = domPwr;
  assign periphPwr = domPwr;
  assign bankPwr   = domPwr;
  assign retainPwr = 1'b1;
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk
  import hib_pkg::*;
#(
  parameter int LPM_W = 2,
  parameter logic [LPM_W-1:0] LPM_HIB = 2'b10
) (
  input logic               clk,
  input logic               rstN,
  input logic [LPM_W-1:0]   lpmMode,
  input logic               idleExec,
  input logic               cpu2LowPower,
  input logic               isoCfg,
  input logic [STATE_W-1:0] seqState,
  input logic               ioIso,
  input logic               oscEn,
  input logic               corePwr,
  input logic               periphPwr,
  input logic               bankPwr,
  input logic               retainPwr,
  input logic               cpu2RstN,
  input logic               hibCause
);
  assert_entry_R1: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_RUN && lpmMode == LPM_HIB && idleExec && cpu2LowPower)
      |=> seqState == ST_ENTER);

  assert_hib_power_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_HIB |-> (!corePwr && !periphPwr && !bankPwr && retainPwr && !cpu2RstN));

  assert_iso_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_ENTER |=> ioIso == $past(isoCfg));

  assert_osc_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> (seqState == ST_CLK_UP && $past(seqState) == ST_HIB && !corePwr));

  assert_abort_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_HIB && $past(seqState) == ST_CLK_UP) |-> !oscEn);

  assert_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hibCause) |-> $past(seqState) == ST_POWER_UP);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpu2RstN) |-> (!ioIso && $past(seqState) == ST_RELEASE));
endmodule

bind hib_seq hib_seq_chk #(.LPM_W(LPM_W), .LPM_HIB(LPM_HIB)) u_chk (
  .clk(clk), .rstN(rstN), .lpmMode(lpmMode), .idleExec(idleExec),
  .cpu2LowPower(cpu2LowPower), .isoCfg(isoCfg), .seqState(seqState),
  .ioIso(ioIso), .oscEn(oscEn), .corePwr(corePwr), .periphPwr(periphPwr),
  .bankPwr(bankPwr), .retainPwr(retainPwr), .cpu2RstN(cpu2RstN),
  .hibCause(hibCause)
);

// File: tb/tb_hib_seq.sv
module tb_hib_seq;
  localparam logic [3:0] S_RUN = 4'd0, S_ENTER = 4'd1, S_HIB = 4'd2,
    S_CLKUP = 4'd3, S_CLKRDY = 4'd4, S_PWRUP = 4'd5, S_TRIM = 4'd6,
    S_RESTORE = 4'd7, S_RELEASE = 4'd8;
  localparam logic [3:0] BM_N = 4'h3, BM_H = 4'hA;
  localparam logic [15:0] M_ALL = 16'hFFFF, M_ST = 16'hF000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] lpmMode = 2'b00;
  logic idleExec = 0, cpu2LowPower = 0, isoCfg = 0, restoreEn = 0, wakeN = 1;
  logic trimDone = 0, restoreDone = 0, swIsoClr = 0, swCauseClr = 0;
  logic [7:0] minLow = 8'd6;
  logic [3:0] seqState, bootMode;
  logic ioIso, oscEn, corePwr, periphPwr, bankPwr, retainPwr, cpu2RstN, hibCause;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct { string req; logic [15:0] exp; logic [15:0] mask; } item_t;
  item_t sbq[$];
  event pushEv;

  always #2 clk = ~clk;

  hib_seq dut (
    .clk(clk), .rstN(rstN), .lpmMode(lpmMode), .idleExec(idleExec),
    .cpu2LowPower(cpu2LowPower), .isoCfg(isoCfg), .restoreEn(restoreEn),
    .wakeN(wakeN), .minLow(minLow), .trimDone(trimDone),
    .restoreDone(restoreDone), .swIsoClr(swIsoClr), .swCauseClr(swCauseClr),
    .bootModeHib(BM_H), .bootModeNorm(BM_N), .seqState(seqState),
    .ioIso(ioIso), .oscEn(oscEn), .corePwr(corePwr), .periphPwr(periphPwr),
    .bankPwr(bankPwr), .retainPwr(retainPwr), .cpu2RstN(cpu2RstN),
    .hibCause(hibCause), .bootMode(bootMode)
  );

  wire [15:0] obs = {seqState, ioIso, oscEn, corePwr, periphPwr, bankPwr,
                     retainPwr, cpu2RstN, hibCause, bootMode};

  function automatic logic [15:0] mk(logic [3:0] st, logic iso, logic osc,
                                     logic pwr, logic c2, logic cause);
    return {st, iso, osc, pwr, pwr, pwr, 1'b1, c2, cause, cause ? BM_H : BM_N};
  endfunction

  task automatic push(string req, logic [15:0] exp, logic [15:0] mask);
    item_t it;
    it.req = req; it.exp = exp; it.mask = mask;
    sbq.push_back(it);
    -> pushEv;
  endtask

  task automatic drain();
    while (sbq.size() != 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.req, obs & it.mask, it.exp & it.mask);
      end
    end
  endtask

  initial forever begin
    @(pushEv);
    drain();
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic enterHib(logic iso, logic cause);
    lpmMode = 2'b10; idleExec = 1; cpu2LowPower = 1; isoCfg = iso;
    tick();
    lpmMode = 2'b00; idleExec = 0; cpu2LowPower = 0;
    push("R1 enter", {S_ENTER, 12'h0}, M_ST);
    tick();
    push("R2 R3 hib", mk(S_HIB, iso, 0, 0, 0, cause), M_ALL);
  endtask

  task automatic wakeToTrim(logic iso, logic cause);
    wakeN = 0; tick();
    push("R4 clk up", mk(S_CLKUP, iso, 1, 0, 0, cause), M_ALL);
    repeat (3) tick();
    push("R6 still counting", {S_CLKUP, 12'h0}, M_ST);
    repeat (7) tick();
    push("R6 clk ready", mk(S_CLKRDY, iso, 1, 0, 0, cause), M_ALL);
    wakeN = 1; tick();
    push("R6 power up", mk(S_PWRUP, iso, 1, 0, 0, cause), M_ALL);
    tick();
    push("R6 R11 trim", mk(S_TRIM, iso, 1, 1, 0, 1), M_ALL);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1; tick();
    push("R2 R11 reset", mk(S_RUN, 0, 1, 1, 1, 0), M_ALL);

    lpmMode = 2'b10; idleExec = 1; cpu2LowPower = 0; tick();
    push("R1 no cpu2 idle", {S_RUN, 12'h0}, M_ST);
    lpmMode = 2'b01; cpu2LowPower = 1; tick();
    push("R1 wrong mode", {S_RUN, 12'h0}, M_ST);
    lpmMode = 2'b10; idleExec = 0; tick();
    push("R1 no idle", {S_RUN, 12'h0}, M_ST);
    lpmMode = 2'b00; cpu2LowPower = 0;

    enterHib(1, 0);
    repeat (3) tick();
    push("R2 stays hib", mk(S_HIB, 1, 0, 0, 0, 0), M_ALL);

    wakeN = 0; tick();
    push("R4 short clk up", mk(S_CLKUP, 1, 1, 0, 0, 0), M_ALL);
    wakeN = 1; tick();
    push("R5 early rise", mk(S_HIB, 1, 0, 0, 0, 0), M_ALL);
    tick();

    wakeToTrim(1, 0);
    swIsoClr = 1; tick();
    push("R8 ignored in trim", mk(S_TRIM, 1, 1, 1, 0, 1), M_ALL);
    swIsoClr = 0; repeat (2) tick();
    push("R7 waits trim", {S_TRIM, 12'h0}, M_ST);
    restoreEn = 1; trimDone = 1; tick(); trimDone = 0;
    push("R7 restore", mk(S_RESTORE, 1, 1, 1, 0, 1), M_ALL);
    swIsoClr = 1; tick(); swIsoClr = 0;
    push("R8 sw clear", mk(S_RESTORE, 0, 1, 1, 0, 1), M_ALL);
    restoreDone = 1; tick(); restoreDone = 0;
    push("R7 release", mk(S_RELEASE, 0, 1, 1, 0, 1), M_ALL);
    tick();
    push("R9 run", mk(S_RUN, 0, 1, 1, 1, 1), M_ALL);
    tick();
    push("R10 sticky", mk(S_RUN, 0, 1, 1, 1, 1), M_ALL);
    swCauseClr = 1; tick(); swCauseClr = 0;
    push("R10 R11 sw clear", mk(S_RUN, 0, 1, 1, 1, 0), M_ALL);

    enterHib(1, 0);
    tick();
    wakeToTrim(1, 0);
    trimDone = 1; tick(); trimDone = 0;
    restoreDone = 1; tick(); restoreDone = 0;
    push("R9 release iso held", mk(S_RELEASE, 1, 1, 1, 0, 1), M_ALL);
    tick();
    push("R9 auto clear", mk(S_RUN, 0, 1, 1, 1, 1), M_ALL);

    restoreEn = 0;
    enterHib(0, 1);
    tick();
    wakeToTrim(0, 1);
    trimDone = 1; tick(); trimDone = 0;
    push("R7 skip restore", mk(S_RELEASE, 0, 1, 1, 0, 1), M_ALL);
    tick();
    push("R9 run no iso", mk(S_RUN, 0, 1, 1, 1, 1), M_ALL);

    rstN = 0; tick(); rstN = 1; tick();
    push("R10 reset clears", mk(S_RUN, 0, 1, 1, 1, 0), M_ALL);

    tick();
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule